// File: doc/BRIEF.md
# Main/Side Road Junction Signal Controller

This block sequences the signal lamps at a junction where a busy main road meets a quieter side road. It has five phases: main green, main yellow, all red, side green and side yellow. Each phase runs for at least a minimum number of clock cycles. That minimum is set by a per-phase parameter and counted down by an internal phase timer, which reloads whenever the phase changes. The lamps and the walk indicator are a pure function of the current phase, so the controller is a Moore machine.

The main road gives up its green only when the main-road release qualifier is high and the timer has run out. The side road keeps its green until its vehicle sensor reports traffic and its timer has run out. A pedestrian walk request is remembered until it is served. When main yellow ends with a request pending, the controller inserts an all-red phase with the walk indicator lit. When no request is pending, main yellow goes straight to side green.

Top module: `junction_ctrl`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the controller enters main green, reloads its timer with the main-green duration and clears any pending walk request. After that edge `main_lamp` is 3'b001, `side_lamp` is 3'b100 and `walk_on` is 0.
- R2: Lamp vectors use bit 0 for green, bit 1 for yellow and bit 2 for red. Exactly one bit of each vector is set in every phase. `main_lamp` is green in main green, yellow in main yellow and red otherwise. `side_lamp` is green in side green, yellow in side yellow and red otherwise.
- R3: Main green moves to main yellow only at an edge where `main_req` is high and the timer has expired. Otherwise it stays in main green.
- R4: When main yellow's timer has expired, the next edge moves to all red if a walk request is pending and to side green if none is pending.
- R5: All red moves to side green when its timer expires. `walk_on` is 1 in all red and 0 in every other phase, and both roads show red during all red.
- R6: Side green moves to side yellow only at an edge where `side_sensor` is high and the timer has expired. Side yellow returns to main green when its timer expires.
- R7: On every phase change the timer loads that phase's duration D. It counts down by one per cycle and reports expiry at zero, so a phase whose exit condition is already true lasts exactly D+1 cycles.
- R8: A walk request that is high at any edge becomes pending and stays pending after `walk_req` falls. The pending request is cleared at the edge that leaves all red. A request that is high on that same edge is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| main_req | input | 1 | Permission for the main road to release its green |
| side_sensor | input | 1 | Side-road vehicle presence |
| walk_req | input | 1 | Pedestrian crossing request |
| main_lamp | output | 3 | Main-road lamps {red, yellow, green} |
| side_lamp | output | 3 | Side-road lamps {red, yellow, green} |
| walk_on | output | 1 | Walk indicator |

## Verification
The bench holds every combination of the three request inputs constant and then applies a long pseudo-random stream. On every cycle it compares the lamps against an arithmetic model of the phase and the countdown. Phase lengths are checked to the exact cycle. A controller that reloads the timer one cycle late, or that leaves a phase on expiry alone, shows up as a phase one cycle too long or one that ends early. Directed walk sequences check two things. A one-cycle request must still produce an all-red phase. A request must not linger into the next main-yellow decision, or a second all-red phase would appear when no request was made.

// File: rtl/junction_pkg.sv
// Shared phase encoding for the junction controller.
// Assumes three state bits are enough for the five phases.
package junction_pkg;
    typedef enum logic [2:0] {
        PH_MAIN_GO   = 3'd0,
        PH_MAIN_WARN = 3'd1,
        PH_ALL_STOP  = 3'd2,
        PH_SIDE_GO   = 3'd3,
        PH_SIDE_WARN = 3'd4
    } phase_t;

    localparam int LAMP_W = 3;
endpackage

// File: rtl/jc_phase_timer.sv
// Down-counting phase timer. It loads load_val when load is high and
// otherwise decrements until it reaches zero. expired is high while the
// count is zero. Reset loads RST_VAL. Assumes load_val fits in W bits.
module jc_phase_timer #(
    parameter int W       = 4,
    parameter int RST_VAL = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] count_q;

    // Reload on a phase change, otherwise count down to zero and hold.
    always_ff @(posedge clk) begin
        if (!rst_n)              count_q <= W'(RST_VAL);
        else if (load)           count_q <= load_val;
        else if (count_q != '0)  count_q <= count_q - 1'b1;
    end

    assign expired = (count_q == '0);

    // R7
    stays_expired_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && !load) |=> expired);
endmodule

// File: rtl/jc_walk_latch.sv
// Holds a pedestrian request from the edge it is seen until the edge on
// which the controller leaves the all-red phase. Clearing wins over a
// request arriving on that same edge.
module jc_walk_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic walk_req,
    input  logic serve_done,
    output logic pending
);
    // Set on any request and clear once the all-red phase is left.
    always_ff @(posedge clk) begin
        if (!rst_n)          pending <= 1'b0;
        else if (serve_done) pending <= 1'b0;
        else if (walk_req)   pending <= 1'b1;
    end

    // R8
    pend_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        serve_done |=> !pending);
endmodule

// File: rtl/jc_lamp_decode.sv
// Moore output decode. Outputs take default values first and are then
// overridden by phase. Lamp bits are {red, yellow, green}.
module jc_lamp_decode
    import junction_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  phase_t            phase,
    output logic [LAMP_W-1:0] main_lamp,
    output logic [LAMP_W-1:0] side_lamp,
    output logic              walk_on
);
    // Drive the lamps from the phase alone, red by default.
    always_comb begin
        main_lamp = 3'b100;
        side_lamp = 3'b100;
        walk_on   = 1'b0;
        case (phase)
            PH_MAIN_GO:   main_lamp = 3'b001;
            PH_MAIN_WARN: main_lamp = 3'b010;
            PH_ALL_STOP:  walk_on   = 1'b1;
            PH_SIDE_GO:   side_lamp = 3'b001;
            PH_SIDE_WARN: side_lamp = 3'b010;
            default: ;
        endcase
    end

    // R2
    one_lamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(main_lamp) == 1) && ($countones(side_lamp) == 1));
    // R5
    walk_red_chk: assert property (@(posedge clk) disable iff (!rst_n)
        walk_on |-> (main_lamp[2] && side_lamp[2]));
endmodule

// File: rtl/junction_ctrl.sv
// Junction signal controller top. It holds the phase register and the
// next-phase logic and connects the timer, the walk latch and the lamp
// decode. Each D_* parameter is the count loaded on entry to that phase.
module junction_ctrl
    import junction_pkg::*;
#(
    parameter int D_MAIN_GO   = 6,
    parameter int D_MAIN_WARN = 2,
    parameter int D_ALL_STOP  = 3,
    parameter int D_SIDE_GO   = 4,
    parameter int D_SIDE_WARN = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              main_req,
    input  logic              side_sensor,
    input  logic              walk_req,
    output logic [LAMP_W-1:0] main_lamp,
    output logic [LAMP_W-1:0] side_lamp,
    output logic              walk_on
);
    localparam int D_MAX_A = (D_MAIN_GO > D_MAIN_WARN) ? D_MAIN_GO : D_MAIN_WARN;
    localparam int D_MAX_B = (D_SIDE_GO > D_SIDE_WARN) ? D_SIDE_GO : D_SIDE_WARN;
    localparam int D_MAX_C = (D_MAX_A > D_MAX_B) ? D_MAX_A : D_MAX_B;
    localparam int D_MAX   = (D_MAX_C > D_ALL_STOP) ? D_MAX_C : D_ALL_STOP;
    localparam int TW      = $clog2(D_MAX + 1);

    phase_t        phase_q, phase_d;
    logic          expired, pending, load, serve_done;
    logic [TW-1:0] reload;

    // Next-phase logic: hold by default and leave only on expiry.
    always_comb begin
        phase_d = phase_q;
        case (phase_q)
            PH_MAIN_GO:   if (main_req && expired)    phase_d = PH_MAIN_WARN;
            PH_MAIN_WARN: if (expired)                phase_d = pending ? PH_ALL_STOP : PH_SIDE_GO;
            PH_ALL_STOP:  if (expired)                phase_d = PH_SIDE_GO;
            PH_SIDE_GO:   if (side_sensor && expired) phase_d = PH_SIDE_WARN;
            PH_SIDE_WARN: if (expired)                phase_d = PH_MAIN_GO;
            default:                                  phase_d = PH_MAIN_GO;
        endcase
    end

    // Pick the duration of the phase being entered.
    always_comb begin
        reload = TW'(D_MAIN_GO);
        case (phase_d)
            PH_MAIN_WARN: reload = TW'(D_MAIN_WARN);
            PH_ALL_STOP:  reload = TW'(D_ALL_STOP);
            PH_SIDE_GO:   reload = TW'(D_SIDE_GO);
            PH_SIDE_WARN: reload = TW'(D_SIDE_WARN);
            default: ;
        endcase
    end

    assign load       = (phase_d != phase_q);
    assign serve_done = (phase_q == PH_ALL_STOP) && load;

    // Phase register with synchronous reset to main green.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PH_MAIN_GO;
        else        phase_q <= phase_d;
    end

    jc_phase_timer #(.W(TW), .RST_VAL(D_MAIN_GO)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(load), .load_val(reload), .expired(expired)
    );

    jc_walk_latch u_walk (
        .clk(clk), .rst_n(rst_n), .walk_req(walk_req),
        .serve_done(serve_done), .pending(pending)
    );

    jc_lamp_decode u_lamps (
        .clk(clk), .rst_n(rst_n), .phase(phase_q),
        .main_lamp(main_lamp), .side_lamp(side_lamp), .walk_on(walk_on)
    );

    // R1
    reset_phase_chk: assert property (@(posedge clk)
        !rst_n |=> (phase_q == PH_MAIN_GO));
    // R7
    leave_on_expiry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> expired);
    // R4
    stop_needs_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_MAIN_WARN && phase_d == PH_ALL_STOP) |-> pending);
    // R6
    side_needs_car_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_SIDE_GO && load) |-> side_sensor);
    // R3
    main_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_MAIN_GO && load) |-> main_req);
endmodule

// File: tb/junction_ctrl_tb.sv
module junction_ctrl_tb;
    localparam int DMG = 6, DMY = 2, DAR = 3, DSG = 4, DSY = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0, main_req = 1'b0, side_sensor = 1'b0, walk_req = 1'b0;
    logic [2:0] main_lamp, side_lamp;
    logic walk_on;

    int n_vec = 0, n_bad = 0;
    int m_st = 0, m_cnt = DMG;
    bit m_pend = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    junction_ctrl #(.D_MAIN_GO(DMG), .D_MAIN_WARN(DMY), .D_ALL_STOP(DAR),
                    .D_SIDE_GO(DSG), .D_SIDE_WARN(DSY)) u_dut (
        .clk(clk), .rst_n(rst_n), .main_req(main_req), .side_sensor(side_sensor),
        .walk_req(walk_req), .main_lamp(main_lamp), .side_lamp(side_lamp),
        .walk_on(walk_on)
    );

    function automatic int dur(input int s);
        case (s)
            0: return DMG;
            1: return DMY;
            2: return DAR;
            3: return DSG;
            default: return DSY;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One clock: drive inputs, advance the model, compare after the edge.
    task automatic step(input logic r, input logic mr, input logic ss, input logic wr);
        int nx;
        bit ex;
        string tag;
        logic [2:0] em, es;
        @(negedge clk);
        rst_n = r; main_req = mr; side_sensor = ss; walk_req = wr;
        if (!r) begin
            m_st = 0; m_cnt = DMG; m_pend = 0; tag = "R1";
        end else begin
            ex = (m_cnt == 0);
            nx = m_st;
            case (m_st)
                0: if (mr && ex) nx = 1;
                1: if (ex) nx = m_pend ? 2 : 3;
                2: if (ex) nx = 3;
                3: if (ss && ex) nx = 4;
                default: if (ex) nx = 0;
            endcase
            case (m_st)
                0: tag = "R3";
                1: tag = "R4";
                2: tag = "R5";
                default: tag = "R6";
            endcase
            if (nx == m_st) tag = "R7";
            if (m_st == 2 && nx != 2) m_pend = 0;
            else if (wr) m_pend = 1;
            if (nx != m_st) m_cnt = dur(nx);
            else if (m_cnt != 0) m_cnt = m_cnt - 1;
            m_st = nx;
        end
        em = (m_st == 0) ? 3'b001 : (m_st == 1) ? 3'b010 : 3'b100;
        es = (m_st == 3) ? 3'b001 : (m_st == 4) ? 3'b010 : 3'b100;
        @(posedge clk);
        #1;
        check(main_lamp == em && side_lamp == es, tag, {main_lamp, side_lamp}, {em, es});
        check(walk_on == (m_st == 2), "R5", walk_on, m_st == 2);
    endtask

    initial begin
        int cyc;
        logic [15:0] lf;
        bit seen;
        repeat (2) step(0, 0, 0, 0);
        // R1: reset state seen at the ports
        check(main_lamp == 3'b001 && side_lamp == 3'b100 && !walk_on, "R1",
              {main_lamp, side_lamp, walk_on}, 7'b0011000);

        // R7: main green lasts DMG+1 cycles with the qualifier held
        cyc = 0;
        while (main_lamp == 3'b001 && cyc < 50) begin step(1, 1, 0, 0); cyc++; end
        check(cyc == DMG + 1, "R7", cyc, DMG + 1);

        // R8: a one-cycle walk pulse in main green leads to an all-red phase
        repeat (2) step(0, 0, 0, 0);
        step(1, 0, 0, 1);
        seen = 0;
        for (int i = 0; i < 40; i++) begin step(1, 1, 1, 0); if (walk_on) seen = 1; end
        check(seen, "R8", seen, 1);
        // R8: served request does not repeat on the next round
        seen = 0;
        for (int i = 0; i < 40; i++) begin step(1, 1, 1, 0); if (walk_on) seen = 1; end
        check(!seen, "R8", seen, 0);

        // R4: with no walk, main yellow goes directly to side green
        repeat (2) step(0, 0, 0, 0);
        for (int i = 0; i < 20; i++) step(1, 1, 0, 0);
        check(side_lamp == 3'b001 && !walk_on, "R4", side_lamp, 3'b001);
        // R6: side green is held while the sensor is low
        for (int i = 0; i < 20; i++) step(1, 1, 0, 0);
        check(side_lamp == 3'b001, "R6", side_lamp, 3'b001);

        // Sweep of all constant input combinations
        for (int c = 0; c < 8; c++) begin
            repeat (2) step(0, 0, 0, 0);
            for (int i = 0; i < 40; i++) step(1, c[0], c[1], c[2]);
        end

        // Pseudo-random stream, including rare resets
        lf = 16'hACE1;
        for (int i = 0; i < 3000; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            step(lf[9:0] != 10'd0, lf[0] | lf[5], lf[1] & lf[3], lf[2] & lf[4] & lf[7]);
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule